// File: doc/BRIEF.md
# Memory Polynomial Predistorter

This block is a streaming predistorter for complex baseband data. On every cycle in which an input sample is marked valid it accepts one signed I/Q pair. After a fixed pipeline delay it emits one predistorted I/Q pair. It keeps two short histories of accepted samples: the complex samples themselves, and the squared magnitude of each one, which is computed once on arrival.

The output is a weighted sum of terms laid out as a grid. The rows are indexed by the memory index `m`, from 0 to `MEM_DEPTH`. Each row has one linear column, which holds the delayed sample x(n-m). Each row also has `MAX_LAG+1` cross columns, which hold x(n-m)·|x(n-m-k)|² for k = 0..`MAX_LAG`. The delayed sample supplies the memory and the squared-magnitude factor supplies the nonlinearity. Every term has its own complex weight, so every weighting is a full complex multiply.

Weights are written one at a time into a shadow bank. An apply strobe then copies the whole shadow bank into the active bank on a single edge. `MEM_DEPTH` is intended for values 3 to 7.

Top module: `mp_predistorter`

## Requirements
- R1: After reset, with only address 0 (the linear term at m = 0) loaded with 1.0 (real 65536, imaginary 0) and applied, every output equals its input sample exactly.
- R2: Weight address m*(MAX_LAG+2)+c selects the term for row m. Column c = 0 is the linear term p = x(n-m). Column c = 1+k is the cross term p = floor(x(n-m)·floor(|x(n-m-k)|² / 2^15) / 2^15), where |x|² = I² + Q². Samples are Q1.15 and weights are Q2.16. The accumulator is S = Σ w·p as a full complex product.
- R3: `outValid` is `inValid` delayed by exactly 4 clock cycles, and no output is valid in the first 4 cycles after reset.
- R4: The histories advance only on cycles with `inValid` high. A tap is one accepted sample, so idle cycles between samples do not change which past samples feed the output.
- R5: Writes go to the shadow bank only and have no effect on the outputs until `coefApply`. The apply copies the entire bank on one edge, so no output mixes old and new weights.
- R6: A weight write to an address at or above (MEM_DEPTH+1)*(MAX_LAG+2) is ignored.
- R7: Each output component is floor((S + 2^15) / 2^16), that is, rounded half up. It is then saturated to the range -32768..32767.
- R8: Reset clears both histories, both weight banks and `outValid`. `outI` and `outQ` are zero on every cycle in which `outValid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Input sample present this cycle |
| inI | input | DATA_W | Input in-phase part, signed Q1.15 |
| inQ | input | DATA_W | Input quadrature part, signed Q1.15 |
| coefWrEn | input | 1 | Write one weight into the shadow bank |
| coefWrAddr | input | ADDR_W | Weight address m*(MAX_LAG+2)+c |
| coefWrRe | input | COEF_W | Weight real part, signed Q2.16 |
| coefWrIm | input | COEF_W | Weight imaginary part, signed Q2.16 |
| coefApply | input | 1 | Copy the shadow bank into the active bank |
| outValid | output | 1 | Output sample present this cycle |
| outI | output | DATA_W | Predistorted in-phase part |
| outQ | output | DATA_W | Predistorted quadrature part |

## Verification
The assertions check the handshake timing on every cycle. They confirm that `outValid` tracks `inValid` four cycles later, that nothing is valid in the first four cycles after reset, and that the data outputs are zero whenever no sample is valid.

The arithmetic can only be shown by the bench's scenarios, which compare outputs against a model computed in the bench. These scenarios cover:
- every weight address driven alone;
- a dense random weight set;
- rounding and saturation edges;
- shadow writes left unapplied, and out-of-range addresses;
- idle gaps inside the stream;
- a reset while samples are still in flight.

// File: rtl/mpd_pkg.sv
package mpd_pkg;
  // strobes from control into the weight banks
  typedef struct packed {
    logic write;
    logic apply;
  } bankCtl_t;

  // strobes from control into the datapath
  typedef struct packed {
    logic advance;
    logic outLoad;
  } pathCtl_t;
endpackage

// File: rtl/mpd_control.sv
module mpd_control
  import mpd_pkg::*;
#(
  parameter int NTERMS  = 12,
  parameter int ADDR_W  = 4,
  parameter int LATENCY = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  logic              coefWrEn,
  input  logic [ADDR_W-1:0] coefWrAddr,
  input  logic              coefApply,
  output bankCtl_t          bankCtl,
  output pathCtl_t          pathCtl,
  output logic              outValid
);
  logic [LATENCY-1:0] validPipe;
  logic               addrOk;

  assign addrOk = (32'(coefWrAddr) < NTERMS);

  always_ff @(posedge clk) begin
    if (rst) validPipe <= '0;
    else     validPipe <= {validPipe[LATENCY-2:0], inValid};
  end

  always_comb begin
    bankCtl.write   = coefWrEn & addrOk;
    bankCtl.apply   = coefApply;
    pathCtl.advance = inValid;
    pathCtl.outLoad = validPipe[LATENCY-2];
  end

  assign outValid = validPipe[LATENCY-1];
endmodule

// File: rtl/mpd_coef_bank.sv
module mpd_coef_bank
  import mpd_pkg::*;
#(
  parameter int COEF_W = 18,
  parameter int NTERMS = 12,
  parameter int ADDR_W = 4
) (
  input  logic                           clk,
  input  logic                           rst,
  input  bankCtl_t                       ctl,
  input  logic [ADDR_W-1:0]              wrAddr,
  input  logic [COEF_W-1:0]              wrRe,
  input  logic [COEF_W-1:0]              wrIm,
  output logic [NTERMS-1:0][COEF_W-1:0]  activeRe,
  output logic [NTERMS-1:0][COEF_W-1:0]  activeIm
);
  logic [NTERMS-1:0][COEF_W-1:0] shadowRe;
  logic [NTERMS-1:0][COEF_W-1:0] shadowIm;

  // shadow bank: one entry per write strobe
  always_ff @(posedge clk) begin
    if (rst) begin
      shadowRe <= '0;
      shadowIm <= '0;
    end else if (ctl.write) begin
      shadowRe[wrAddr] <= wrRe;
      shadowIm[wrAddr] <= wrIm;
    end
  end

  // active bank: whole-bank copy on one edge
  always_ff @(posedge clk) begin
    if (rst) begin
      activeRe <= '0;
      activeIm <= '0;
    end else if (ctl.apply) begin
      activeRe <= shadowRe;
      activeIm <= shadowIm;
    end
  end
endmodule

// File: rtl/mpd_datapath.sv
module mpd_datapath
  import mpd_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int COEF_W    = 18,
  parameter int MEM_DEPTH = 3,
  parameter int MAX_LAG   = 1,
  parameter int NTERMS    = (MEM_DEPTH + 1) * (MAX_LAG + 2)
) (
  input  logic                          clk,
  input  logic                          rst,
  input  pathCtl_t                      ctl,
  input  logic signed [DATA_W-1:0]      inI,
  input  logic signed [DATA_W-1:0]      inQ,
  input  logic [NTERMS-1:0][COEF_W-1:0] coefRe,
  input  logic [NTERMS-1:0][COEF_W-1:0] coefIm,
  output logic signed [DATA_W-1:0]      outI,
  output logic signed [DATA_W-1:0]      outQ
);
  localparam int COLS    = MAX_LAG + 2;
  localparam int X_LEN   = MEM_DEPTH + 1;
  localparam int MAG_LEN = MEM_DEPTH + MAX_LAG + 1;
  localparam int SQ_W    = 2 * DATA_W;
  localparam int MAG_W   = DATA_W + 1;
  localparam int P_W     = DATA_W + 2;
  localparam int WIDE_W  = 2 * DATA_W + 2;
  localparam int TERM_W  = COEF_W + P_W + 1;
  localparam int ACC_W   = TERM_W + $clog2(NTERMS) + 1;
  localparam int FRAC    = COEF_W - 2;
  localparam logic signed [ACC_W-1:0] HALF    = ACC_W'(1) <<< (FRAC - 1);
  localparam logic signed [ACC_W-1:0] OUT_MAX = ACC_W'((64'sd1 <<< (DATA_W - 1)) - 1);
  localparam logic signed [ACC_W-1:0] OUT_MIN = -OUT_MAX - ACC_W'(1);

  // ---------------- squared magnitude of the arriving sample ----------------
  logic signed [SQ_W-1:0] sqI, sqQ;
  logic [SQ_W:0]          magFull;
  logic [MAG_W-1:0]       magNew;

  assign sqI     = SQ_W'(inI) * SQ_W'(inI);
  assign sqQ     = SQ_W'(inQ) * SQ_W'(inQ);
  assign magFull = {1'b0, sqI} + {1'b0, sqQ};
  assign magNew  = MAG_W'(magFull >> (DATA_W - 1));

  // ---------------- history lines (advance on accepted samples) -------------
  logic signed [DATA_W-1:0] xI [X_LEN];
  logic signed [DATA_W-1:0] xQ [X_LEN];
  logic [MAG_W-1:0]         magLine [MAG_LEN];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int j = 0; j < X_LEN; j++) begin
        xI[j] <= '0;
        xQ[j] <= '0;
      end
      for (int j = 0; j < MAG_LEN; j++) magLine[j] <= '0;
    end else if (ctl.advance) begin
      xI[0]      <= inI;
      xQ[0]      <= inQ;
      magLine[0] <= magNew;
      for (int j = 1; j < X_LEN; j++) begin
        xI[j] <= xI[j-1];
        xQ[j] <= xQ[j-1];
      end
      for (int j = 1; j < MAG_LEN; j++) magLine[j] <= magLine[j-1];
    end
  end

  // ---------------- stage 1: basis products per term ------------------------
  logic signed [P_W-1:0] pNextRe [NTERMS];
  logic signed [P_W-1:0] pNextIm [NTERMS];
  logic signed [P_W-1:0] pRe [NTERMS];
  logic signed [P_W-1:0] pIm [NTERMS];

  for (genvar m = 0; m <= MEM_DEPTH; m++) begin : g_row
    for (genvar c = 0; c < COLS; c++) begin : g_col
      localparam int T = m * COLS + c;
      if (c == 0) begin : g_linear
        assign pNextRe[T] = P_W'(xI[m]);
        assign pNextIm[T] = P_W'(xQ[m]);
      end else begin : g_cross
        localparam int LAG = m + c - 1;
        logic signed [WIDE_W-1:0] magS;
        assign magS       = $signed(WIDE_W'(magLine[LAG]));
        assign pNextRe[T] = P_W'((WIDE_W'(xI[m]) * magS) >>> (DATA_W - 1));
        assign pNextIm[T] = P_W'((WIDE_W'(xQ[m]) * magS) >>> (DATA_W - 1));
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int t = 0; t < NTERMS; t++) begin
        pRe[t] <= '0;
        pIm[t] <= '0;
      end
    end else begin
      for (int t = 0; t < NTERMS; t++) begin
        pRe[t] <= pNextRe[t];
        pIm[t] <= pNextIm[t];
      end
    end
  end

  // ---------------- stage 2: complex weighting ------------------------------
  logic signed [TERM_W-1:0] tNextRe [NTERMS];
  logic signed [TERM_W-1:0] tNextIm [NTERMS];
  logic signed [TERM_W-1:0] tRe [NTERMS];
  logic signed [TERM_W-1:0] tIm [NTERMS];

  for (genvar t = 0; t < NTERMS; t++) begin : g_weight
    logic signed [TERM_W-1:0] wRe, wIm, bRe, bIm;
    assign wRe = TERM_W'($signed(coefRe[t]));
    assign wIm = TERM_W'($signed(coefIm[t]));
    assign bRe = TERM_W'(pRe[t]);
    assign bIm = TERM_W'(pIm[t]);
    assign tNextRe[t] = wRe * bRe - wIm * bIm;
    assign tNextIm[t] = wRe * bIm + wIm * bRe;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int t = 0; t < NTERMS; t++) begin
        tRe[t] <= '0;
        tIm[t] <= '0;
      end
    end else begin
      for (int t = 0; t < NTERMS; t++) begin
        tRe[t] <= tNextRe[t];
        tIm[t] <= tNextIm[t];
      end
    end
  end

  // ---------------- stage 3: sum, round, saturate ---------------------------
  logic signed [ACC_W-1:0] accRe, accIm, shRe, shIm;

  always_comb begin
    accRe = '0;
    accIm = '0;
    for (int t = 0; t < NTERMS; t++) begin
      accRe = accRe + ACC_W'(tRe[t]);
      accIm = accIm + ACC_W'(tIm[t]);
    end
  end

  assign shRe = (accRe + HALF) >>> FRAC;
  assign shIm = (accIm + HALF) >>> FRAC;

  function automatic logic signed [DATA_W-1:0] clampOut(input logic signed [ACC_W-1:0] v);
    if (v > OUT_MAX)      return DATA_W'(OUT_MAX);
    else if (v < OUT_MIN) return DATA_W'(OUT_MIN);
    else                  return DATA_W'(v);
  endfunction

  always_ff @(posedge clk) begin
    if (rst || !ctl.outLoad) begin
      outI <= '0;
      outQ <= '0;
    end else begin
      outI <= clampOut(shRe);
      outQ <= clampOut(shIm);
    end
  end
endmodule

// File: rtl/mp_predistorter.sv
module mp_predistorter
  import mpd_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int COEF_W    = 18,
  parameter int MEM_DEPTH = 3,
  parameter int MAX_LAG   = 1,
  localparam int NTERMS   = (MEM_DEPTH + 1) * (MAX_LAG + 2),
  localparam int ADDR_W   = $clog2(NTERMS)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     inValid,
  input  logic signed [DATA_W-1:0] inI,
  input  logic signed [DATA_W-1:0] inQ,
  input  logic                     coefWrEn,
  input  logic [ADDR_W-1:0]        coefWrAddr,
  input  logic [COEF_W-1:0]        coefWrRe,
  input  logic [COEF_W-1:0]        coefWrIm,
  input  logic                     coefApply,
  output logic                     outValid,
  output logic signed [DATA_W-1:0] outI,
  output logic signed [DATA_W-1:0] outQ
);
  localparam int LATENCY = 4;

  bankCtl_t                      bankCtl;
  pathCtl_t                      pathCtl;
  logic [NTERMS-1:0][COEF_W-1:0] activeRe;
  logic [NTERMS-1:0][COEF_W-1:0] activeIm;

  mpd_control #(
    .NTERMS (NTERMS),
    .ADDR_W (ADDR_W),
    .LATENCY(LATENCY)
  ) u_control (
    .clk       (clk),
    .rst       (rst),
    .inValid   (inValid),
    .coefWrEn  (coefWrEn),
    .coefWrAddr(coefWrAddr),
    .coefApply (coefApply),
    .bankCtl   (bankCtl),
    .pathCtl   (pathCtl),
    .outValid  (outValid)
  );

  mpd_coef_bank #(
    .COEF_W(COEF_W),
    .NTERMS(NTERMS),
    .ADDR_W(ADDR_W)
  ) u_bank (
    .clk     (clk),
    .rst     (rst),
    .ctl     (bankCtl),
    .wrAddr  (coefWrAddr),
    .wrRe    (coefWrRe),
    .wrIm    (coefWrIm),
    .activeRe(activeRe),
    .activeIm(activeIm)
  );

  mpd_datapath #(
    .DATA_W   (DATA_W),
    .COEF_W   (COEF_W),
    .MEM_DEPTH(MEM_DEPTH),
    .MAX_LAG  (MAX_LAG),
    .NTERMS   (NTERMS)
  ) u_path (
    .clk   (clk),
    .rst   (rst),
    .ctl   (pathCtl),
    .inI   (inI),
    .inQ   (inQ),
    .coefRe(activeRe),
    .coefIm(activeIm),
    .outI  (outI),
    .outQ  (outQ)
  );
endmodule

// File: rtl/mpd_checker.sv
module mpd_checker #(
  parameter int DATA_W  = 16,
  parameter int LATENCY = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              inValid,
  input logic              outValid,
  input logic [DATA_W-1:0] outI,
  input logic [DATA_W-1:0] outQ
);
  logic [3:0] sinceRst;

  always_ff @(posedge clk) begin
    if (rst)                  sinceRst <= '0;
    else if (sinceRst != 4'd15) sinceRst <= sinceRst + 4'd1;
  end

  // R3
  latency_match_chk: assert property (@(posedge clk) disable iff (rst)
    (32'(sinceRst) >= LATENCY) |-> (outValid == $past(inValid, 4)));

  // R3
  no_early_valid_chk: assert property (@(posedge clk) disable iff (rst)
    outValid |-> (32'(sinceRst) >= LATENCY));

  // R8
  idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !outValid |-> (outI == '0 && outQ == '0));

  // R8
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> !outValid);
endmodule

bind mp_predistorter mpd_checker #(
  .DATA_W (DATA_W),
  .LATENCY(4)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .inValid (inValid),
  .outValid(outValid),
  .outI    (outI),
  .outQ    (outQ)
);

// File: tb/mp_predistorter_bench.sv
module mp_predistorter_bench;
  localparam int DW   = 16;
  localparam int CW   = 18;
  localparam int MD   = 3;
  localparam int ML   = 1;
  localparam int COLS = ML + 2;
  localparam int NT   = (MD + 1) * COLS;
  localparam int AW   = $clog2(NT);
  localparam int HLEN = MD + ML + 1;
  localparam longint ONE = 65536;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic inValid = 1'b0;
  logic signed [DW-1:0] inI = '0, inQ = '0;
  logic coefWrEn = 1'b0;
  logic [AW-1:0] coefWrAddr = '0;
  logic [CW-1:0] coefWrRe = '0, coefWrIm = '0;
  logic coefApply = 1'b0;
  logic outValid;
  logic signed [DW-1:0] outI, outQ;

  always #10 clk = ~clk;

  mp_predistorter #(.DATA_W(DW), .COEF_W(CW), .MEM_DEPTH(MD), .MAX_LAG(ML)) u_mp_predistorter (
    .clk(clk), .rst(rst), .inValid(inValid), .inI(inI), .inQ(inQ),
    .coefWrEn(coefWrEn), .coefWrAddr(coefWrAddr), .coefWrRe(coefWrRe),
    .coefWrIm(coefWrIm), .coefApply(coefApply),
    .outValid(outValid), .outI(outI), .outQ(outQ));

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit done = 1'b0;
  int unsigned seed = 32'h1234_5678;

  typedef struct {
    longint ei;
    longint eq;
    int     at;
    string  tag;
  } exp_t;
  exp_t expQ[$];

  // model state
  longint hI [HLEN];
  longint hQ [HLEN];
  longint shRe [NT];
  longint shIm [NT];
  longint acRe [NT];
  longint acIm [NT];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  function automatic int unsigned nextRand();
    seed = seed * 32'd1664525 + 32'd1013904223;
    return seed;
  endfunction

  function automatic longint sat16(input longint v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  task automatic modelReset();
    for (int j = 0; j < HLEN; j++) begin hI[j] = 0; hQ[j] = 0; end
    for (int t = 0; t < NT; t++) begin shRe[t] = 0; shIm[t] = 0; acRe[t] = 0; acIm[t] = 0; end
    expQ.delete();
  endtask

  // push a sample into the model history and queue the expected output (R2, R7)
  task automatic modelPush(input longint si, input longint sq, input string tag);
    longint sRe, sIm, pr, pi, mq;
    exp_t e;
    for (int j = HLEN - 1; j > 0; j--) begin hI[j] = hI[j-1]; hQ[j] = hQ[j-1]; end
    hI[0] = si; hQ[0] = sq;
    sRe = 0; sIm = 0;
    for (int m = 0; m <= MD; m++) begin
      for (int c = 0; c < COLS; c++) begin
        if (c == 0) begin
          pr = hI[m]; pi = hQ[m];
        end else begin
          mq = (hI[m+c-1] * hI[m+c-1] + hQ[m+c-1] * hQ[m+c-1]) >>> 15;
          pr = (hI[m] * mq) >>> 15;
          pi = (hQ[m] * mq) >>> 15;
        end
        sRe += acRe[m*COLS+c] * pr - acIm[m*COLS+c] * pi;
        sIm += acRe[m*COLS+c] * pi + acIm[m*COLS+c] * pr;
      end
    end
    e.ei = sat16((sRe + 32768) >>> 16);
    e.eq = sat16((sIm + 32768) >>> 16);
    e.at = cyc + 4;
    e.tag = tag;
    expQ.push_back(e);
  endtask

  task automatic send(input longint si, input longint sq, input string tag);
    @(negedge clk);
    inValid = 1'b1;
    inI = DW'(si);
    inQ = DW'(sq);
    modelPush(si, sq, tag);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      inValid = 1'b0;
    end
  endtask

  task automatic writeCoef(input int addr, input longint re, input longint im);
    @(negedge clk);
    inValid = 1'b0;
    coefWrEn = 1'b1;
    coefWrAddr = AW'(addr);
    coefWrRe = CW'(re);
    coefWrIm = CW'(im);
    if (addr < NT) begin shRe[addr] = re; shIm[addr] = im; end
    @(negedge clk);
    coefWrEn = 1'b0;
  endtask

  task automatic applyCoefs();
    @(negedge clk);
    inValid = 1'b0;
    coefApply = 1'b1;
    for (int t = 0; t < NT; t++) begin acRe[t] = shRe[t]; acIm[t] = shIm[t]; end
    @(negedge clk);
    coefApply = 1'b0;
  endtask

  task automatic clearShadow();
    for (int t = 0; t < NT; t++) writeCoef(t, 0, 0);
  endtask

  function automatic longint randSample();
    int unsigned r;
    r = nextRand();
    case (r[31:29])
      3'd0: return -32768;
      3'd1: return 32767;
      3'd2: return longint'($signed(r[15:0])) >>> 8;
      default: return longint'($signed(r[15:0]));
    endcase
  endfunction

  // output monitor: every valid output is compared at its expected cycle (R3)
  always @(negedge clk) begin
    if (!rst && outValid) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R3 unexpected outValid", 1, 0);
      end else begin
        exp_t e;
        e = expQ.pop_front();
        check(cyc == e.at, {e.tag, " R3 latency"}, cyc, e.at);
        check(longint'(outI) == e.ei, {e.tag, " I"}, longint'(outI), e.ei);
        check(longint'(outQ) == e.eq, {e.tag, " Q"}, longint'(outQ), e.eq);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    modelReset();
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R8 reset state
    check(outValid == 1'b0, "R8 outValid after reset", longint'(outValid), 0);
    check(outI == '0 && outQ == '0, "R8 outputs after reset", longint'(outI), 0);

    // R8 zero weights after reset give zero output
    for (int s = 0; s < 20; s++) send(randSample(), randSample(), "R8 zero bank");
    idle(8);

    // R5 shadow write without apply has no effect
    writeCoef(0, ONE, 0);
    for (int s = 0; s < 20; s++) send(randSample(), randSample(), "R5 unapplied");
    idle(8);

    // R1 passthrough with extremes included
    applyCoefs();
    for (int s = 0; s < 64; s++) send(randSample(), randSample(), "R1 passthrough");
    send(-32768, 32767, "R1 passthrough");
    send(32767, -32768, "R1 passthrough");
    idle(8);

    // R2 every address alone, with complex weights
    for (int a = 0; a < NT; a++) begin
      clearShadow();
      writeCoef(a, 40000 - a * 5000, -20000 + a * 3000);
      applyCoefs();
      for (int s = 0; s < 30; s++) send(randSample(), randSample(), "R2 single term");
      idle(8);
    end

    // R4 idle gaps do not shift the history: linear m=3 only
    clearShadow();
    writeCoef(3 * COLS, ONE, 0);
    applyCoefs();
    for (int s = 0; s < 24; s++) begin
      send(randSample(), randSample(), "R4 gapped delay");
      idle(s % 4);
    end
    idle(8);

    // R7 rounding half up with weight 0.5
    clearShadow();
    writeCoef(0, 32768, 0);
    applyCoefs();
    send(1, -1, "R7 round");
    send(3, -3, "R7 round");
    send(5, -5, "R7 round");
    send(32767, -32768, "R7 round");
    idle(8);

    // R7 saturation with weight near 2.0
    writeCoef(0, 131071, 0);
    applyCoefs();
    send(32767, -32768, "R7 saturate");
    send(20000, -20000, "R7 saturate");
    send(100, -100, "R7 saturate");
    idle(8);

    // R6 out-of-range addresses ignored
    clearShadow();
    for (int a = NT; a < (1 << AW); a++) writeCoef(a, ONE, ONE);
    applyCoefs();
    for (int s = 0; s < 16; s++) send(randSample(), randSample(), "R6 bad address");
    idle(8);

    // R2 all weights dense, gapped random stream
    for (int t = 0; t < NT; t++) begin
      int unsigned r;
      r = nextRand();
      writeCoef(t, longint'($signed(r[15:0])) >>> 1, longint'($signed(r[31:16])) >>> 1);
    end
    applyCoefs();
    for (int s = 0; s < 300; s++) begin
      send(randSample(), randSample(), "R2 dense");
      if (s % 7 == 3) idle(1);
    end
    idle(8);

    // R8 reset with samples in flight clears history and banks
    send(12345, -2222, "R8 flushed");
    send(-3000, 4000, "R8 flushed");
    @(negedge clk);
    inValid = 1'b0;
    rst = 1'b1;
    modelReset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(outValid == 1'b0, "R8 outValid after mid reset", longint'(outValid), 0);
    writeCoef(1 * COLS, ONE, 0);
    applyCoefs();
    send(777, -888, "R8 cleared history");
    send(999, 111, "R8 cleared history");
    idle(10);
    check(expQ.size() == 0, "R3 all outputs seen", expQ.size(), 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule